// File: doc/BRIEF.md
# Smart Card Waiting-Time Counter

This block times waiting periods on a smart card interface. Time is counted in elementary time units (ETUs), one per pulse on `etu_tick`. Counting is armed by START bits, which are falling edges on the card I/O line that open a new character. The host programs three 8-bit reload registers, an interrupt enable register and a mode register over a simple synchronous register bus. It reads back a sticky status register, and reading that register clears it.

Depending on the mode code, the block runs an 8-bit auto-reload counter, a separate 16-bit counter, or both together. It can instead join all three reload registers into one 24-bit counter. A terminal count sets a status bit, and each status bit can drive the `irq` output. Some mode codes also open a 12-ETU window at the first qualifying START bit. At the end of that window the selected counters halt until the next mode write.

Top module: `sc_wait_timer`

## Requirements
- R1: After reset, every register reads 0x00, `irq` is low and no counter runs.
- R2: A write to the mode address (3) is ignored while `card_active` is low: the mode read-back keeps its previous value and no counting starts.
- R3: A START is a falling edge of the synchronized `io_in` while no character is in progress. A character is in progress from a START until 10 ETU ticks later, and falling edges inside that span are ignored.
- R4: In modes 0x05, 0x65, 0x75, 0x85, 0xE5 and 0xF5, the 8-bit counter loads reload 1 (address 0) at the first START after the mode write. After that many ticks (0 means 256) it sets status bit 0, reloads and repeats. Later STARTs do not restart it.
- R5: In modes 0x71, 0x75 and 0xF1, the 16-bit counter loads {reload 3, reload 2} (addresses 2 and 1, 0 means 65536) at every START. After that many ticks it sets status bit 1 and then idles until the next START.
- R6: In mode 0x7C, one 24-bit counter loads {reload 3, reload 2, reload 1} at every START. After that many ticks it sets status bit 1.
- R7: A reload register written during a 16-bit or 24-bit count leaves the running count unchanged, and the new value is used from the next START.
- R8: In modes 0x71, 0x75, 0x7C, 0xF1 and 0xF5, a START is ignored while all three reload registers hold zero, so no counter starts.
- R9: Modes 0xE5, 0xF1 and 0xF5 open a window at the first START after the mode write. On the 12th tick of that window, 0xE5 halts the 8-bit counter, 0xF1 halts the 16-bit counter and 0xF5 halts both. A terminal count on that same tick still registers. Halted counters stay halted until the next mode write.
- R10: Mode 0x85 counts like 0x05 but halts all counting on the 12th tick after the first START received while `tx_active` is low. STARTs seen while `tx_active` is high do not open the window.
- R11: Writing 0x00, or any code not listed above, stops every counter and keeps them stopped.
- R12: The status register (address 4) holds timeout-8 in bit 0 and timeout-wide in bit 1. Both bits are sticky. A read returns them and clears them, except that a terminal count in the same cycle wins over the clear.
- R13: `irq` is high exactly when a status bit is set whose matching bit in the enable register (address 5, bits 1:0) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_active | input | 1 | Card powered with its clock running; gates mode writes |
| tx_active | input | 1 | High while the interface transmits on the I/O line |
| io_in | input | 1 | Card I/O line, asynchronous, idles high |
| etu_tick | input | 1 | One-cycle strobe per elementary time unit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data appears the following cycle |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The assertions assume that `etu_tick` is a single-cycle strobe and that all inputs except `io_in` are synchronous to `clk`. They also assume a START never arrives in the same cycle as a tick, because the load would then mask that tick. The stimulus follows these rules: every tick is followed by two idle cycles, and each START pulse is completed before the next tick. Before each new mode, the bench writes 0x00, flushes the character span with ticks, and clears the status by a read. This matches the stop-before-restart rule that software must follow.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    localparam int RL_W   = 8;
    localparam int C16_W  = 2 * RL_W;
    localparam int CW_W   = 3 * RL_W;
    localparam int ADDR_W = 3;
    localparam int STS_W  = 2;

    localparam logic [ADDR_W-1:0] A_RL1  = 3'd0;
    localparam logic [ADDR_W-1:0] A_RL2  = 3'd1;
    localparam logic [ADDR_W-1:0] A_RL3  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd3;
    localparam logic [ADDR_W-1:0] A_STS  = 3'd4;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd5;

    localparam logic [RL_W-1:0] MC_STOP   = 8'h00;
    localparam logic [RL_W-1:0] MC_C8     = 8'h05;
    localparam logic [RL_W-1:0] MC_C8B    = 8'h65;
    localparam logic [RL_W-1:0] MC_W16    = 8'h71;
    localparam logic [RL_W-1:0] MC_BOTH   = 8'h75;
    localparam logic [RL_W-1:0] MC_W24    = 8'h7C;
    localparam logic [RL_W-1:0] MC_C8_RXW = 8'h85;
    localparam logic [RL_W-1:0] MC_C8_W   = 8'hE5;
    localparam logic [RL_W-1:0] MC_W16_W  = 8'hF1;
    localparam logic [RL_W-1:0] MC_BOTH_W = 8'hF5;

    typedef struct packed {
        logic c8_en;     // 8-bit auto-reload counter enabled
        logic wide_en;   // 16-bit or 24-bit counter enabled
        logic wide24;    // wide counter spans all three reload registers
        logic halt_c8;   // window end halts the 8-bit counter
        logic halt_w;    // window end halts the wide counter
        logic rx_only;   // window opened only by a received START
    } mode_cfg_t;

    function automatic mode_cfg_t decode_mode(input logic [RL_W-1:0] code);
        mode_cfg_t m;
        m = '0;
        case (code)
            MC_C8, MC_C8B: m.c8_en = 1'b1;
            MC_W16:        m.wide_en = 1'b1;
            MC_BOTH:       begin m.c8_en = 1'b1; m.wide_en = 1'b1; end
            MC_W24:        begin m.wide_en = 1'b1; m.wide24 = 1'b1; end
            MC_C8_RXW:     begin m.c8_en = 1'b1; m.halt_c8 = 1'b1;
                                 m.halt_w = 1'b1; m.rx_only = 1'b1; end
            MC_C8_W:       begin m.c8_en = 1'b1; m.halt_c8 = 1'b1; end
            MC_W16_W:      begin m.wide_en = 1'b1; m.halt_w = 1'b1; end
            MC_BOTH_W:     begin m.c8_en = 1'b1; m.wide_en = 1'b1;
                                 m.halt_c8 = 1'b1; m.halt_w = 1'b1; end
            default:       m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wtc_start_det.sv
module wtc_start_det #(
    parameter int SYNC_STAGES = 2,
    parameter int CHAR_ETUS   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic io_in,
    input  logic tx_active,
    input  logic tick_i,
    output logic start_o,
    output logic start_rx_o
);
    localparam int BC_W = $clog2(CHAR_ETUS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   busy_q;
    logic [BC_W-1:0]        bcnt_q;
    logic                   line;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= io_in;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], io_in};
            end
        end
    endgenerate

    assign line       = sync_q[SYNC_STAGES-1];
    assign start_o    = prev_q & ~line & ~busy_q;
    assign start_rx_o = start_o & ~tx_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            busy_q <= 1'b0;
            bcnt_q <= '0;
        end else begin
            prev_q <= line;
            if (start_o) begin
                busy_q <= 1'b1;
                bcnt_q <= '0;
            end else if (busy_q && tick_i) begin
                if (bcnt_q == BC_W'(CHAR_ETUS - 1)) busy_q <= 1'b0;
                bcnt_q <= bcnt_q + 1'b1;
            end
        end
    end

    // R3
    busy_span_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

endmodule

// File: rtl/wtc_regs.sv
module wtc_regs
    import wtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              card_active,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [RL_W-1:0]   wr_data,
    input  logic              term8_i,
    input  logic              termw_i,
    output logic [RL_W-1:0]   rl1_o,
    output logic [RL_W-1:0]   rl2_o,
    output logic [RL_W-1:0]   rl3_o,
    output logic [RL_W-1:0]   mode_o,
    output logic              mode_load_o,
    output logic [RL_W-1:0]   rd_data,
    output logic              irq
);
    logic [STS_W-1:0] sts_q;
    logic [STS_W-1:0] ien_q;
    logic             sts_rd;

    assign mode_load_o = wr_en && (addr == A_MODE) && card_active;
    assign sts_rd      = rd_en && (addr == A_STS);
    assign irq         = |(sts_q & ien_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rl1_o  <= '0;
            rl2_o  <= '0;
            rl3_o  <= '0;
            mode_o <= MC_STOP;
            ien_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                A_RL1:  rl1_o <= wr_data;
                A_RL2:  rl2_o <= wr_data;
                A_RL3:  rl3_o <= wr_data;
                A_MODE: if (card_active) mode_o <= wr_data;
                A_IEN:  ien_q <= wr_data[STS_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= (sts_rd ? '0 : sts_q) | {termw_i, term8_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (addr)
                A_RL1:   rd_data <= rl1_o;
                A_RL2:   rd_data <= rl2_o;
                A_RL3:   rd_data <= rl3_o;
                A_MODE:  rd_data <= mode_o;
                A_STS:   rd_data <= {{(RL_W-STS_W){1'b0}}, sts_q};
                A_IEN:   rd_data <= {{(RL_W-STS_W){1'b0}}, ien_q};
                default: rd_data <= '0;
            endcase
        end
    end

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_MODE && !card_active) |=> $stable(mode_o));

    // R12
    sts_set_chk: assert property (@(posedge clk) disable iff (rst)
        (term8_i && termw_i) |=> (sts_q == 2'b11));

    // R12
    sts_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (sts_rd && !term8_i && !termw_i) |=> (sts_q == '0));

endmodule

// File: rtl/wtc_counters.sv
module wtc_counters
    import wtc_pkg::*;
#(
    parameter int GUARD_ETUS = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mode_load_i,
    input  mode_cfg_t       cfg_i,
    input  logic [RL_W-1:0] rl1_i,
    input  logic [RL_W-1:0] rl2_i,
    input  logic [RL_W-1:0] rl3_i,
    input  logic            start_i,
    input  logic            start_rx_i,
    input  logic            tick_i,
    output logic            term8_o,
    output logic            termw_o
);
    localparam int GW = $clog2(GUARD_ETUS + 1);

    logic [RL_W-1:0] c8_cnt_q;
    logic            c8_run_q, c8_halt_q;
    logic [CW_W-1:0] cw_cnt_q;
    logic            cw_run_q, cw_halt_q;
    logic [GW-1:0]   win_cnt_q;
    logic            win_run_q, win_used_q;

    logic            cfg_err, c8_go, cw_go, win_go, stop_evt;
    logic [CW_W-1:0] wide_load;

    assign cfg_err  = cfg_i.wide_en && ({rl3_i, rl2_i, rl1_i} == '0);
    assign c8_go    = start_i && cfg_i.c8_en && !c8_run_q && !c8_halt_q && !cfg_err;
    assign cw_go    = start_i && cfg_i.wide_en && !cw_halt_q;
    assign win_go   = start_i && (cfg_i.halt_c8 || cfg_i.halt_w) && !win_used_q
                      && !cfg_err && (!cfg_i.rx_only || start_rx_i);
    assign stop_evt = win_run_q && tick_i && (win_cnt_q == GW'(GUARD_ETUS - 1));

    always_comb begin
        if (cfg_i.wide24)
            wide_load = {rl3_i, rl2_i, rl1_i};
        else if ({rl3_i, rl2_i} == '0)
            wide_load = CW_W'(1) << C16_W;
        else
            wide_load = {{(CW_W-C16_W){1'b0}}, rl3_i, rl2_i};
    end

    assign term8_o = c8_run_q && tick_i && (c8_cnt_q == RL_W'(1));
    assign termw_o = cw_run_q && tick_i && (cw_cnt_q == CW_W'(1)) && !cw_go;

    // 12-ETU stop window
    always_ff @(posedge clk) begin
        if (rst || mode_load_i) begin
            win_run_q  <= 1'b0;
            win_used_q <= 1'b0;
            win_cnt_q  <= '0;
        end else if (win_go) begin
            win_run_q  <= 1'b1;
            win_used_q <= 1'b1;
            win_cnt_q  <= '0;
        end else if (win_run_q && tick_i) begin
            if (stop_evt) win_run_q <= 1'b0;
            else          win_cnt_q <= win_cnt_q + 1'b1;
        end
    end

    // 8-bit auto-reload counter
    always_ff @(posedge clk) begin
        if (rst || mode_load_i) begin
            c8_run_q  <= 1'b0;
            c8_halt_q <= 1'b0;
            c8_cnt_q  <= '0;
        end else begin
            if (c8_go) begin
                c8_run_q <= 1'b1;
                c8_cnt_q <= rl1_i;
            end else if (c8_run_q && tick_i) begin
                c8_cnt_q <= (c8_cnt_q == RL_W'(1)) ? rl1_i : c8_cnt_q - 1'b1;
            end
            if (stop_evt && cfg_i.halt_c8) begin
                c8_run_q  <= 1'b0;
                c8_halt_q <= 1'b1;
            end
        end
    end

    // 16-bit / 24-bit one-shot counter, re-armed by each START
    always_ff @(posedge clk) begin
        if (rst || mode_load_i) begin
            cw_run_q  <= 1'b0;
            cw_halt_q <= 1'b0;
            cw_cnt_q  <= '0;
        end else begin
            if (cw_go) begin
                cw_run_q <= !cfg_err;
                cw_cnt_q <= wide_load;
            end else if (cw_run_q && tick_i) begin
                if (cw_cnt_q == CW_W'(1)) cw_run_q <= 1'b0;
                cw_cnt_q <= cw_cnt_q - 1'b1;
            end
            if (stop_evt && cfg_i.halt_w) begin
                cw_run_q  <= 1'b0;
                cw_halt_q <= 1'b1;
            end
        end
    end

    // R11
    idle_after_mode_chk: assert property (@(posedge clk) disable iff (rst)
        mode_load_i |=> (!c8_run_q && !cw_run_q));

    // R8
    zero_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && cfg_err && !cw_run_q) |=> !cw_run_q);

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (c8_halt_q && !mode_load_i) |=> (c8_halt_q && !c8_run_q));

    // R9
    window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        win_cnt_q < GW'(GUARD_ETUS));

endmodule

// File: rtl/sc_wait_timer.sv
module sc_wait_timer
    import wtc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CHAR_ETUS   = 10,
    parameter int GUARD_ETUS  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              card_active,
    input  logic              tx_active,
    input  logic              io_in,
    input  logic              etu_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [RL_W-1:0]   wr_data,
    output logic [RL_W-1:0]   rd_data,
    output logic              irq
);
    logic [RL_W-1:0] rl1, rl2, rl3, mode_code;
    logic            mode_load, start, start_rx, term8, termw;
    mode_cfg_t       cfg;

    assign cfg = decode_mode(mode_code);

    wtc_start_det #(
        .SYNC_STAGES(SYNC_STAGES),
        .CHAR_ETUS  (CHAR_ETUS)
    ) u_start (
        .clk       (clk),
        .rst       (rst),
        .io_in     (io_in),
        .tx_active (tx_active),
        .tick_i    (etu_tick),
        .start_o   (start),
        .start_rx_o(start_rx)
    );

    wtc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .card_active(card_active),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .term8_i    (term8),
        .termw_i    (termw),
        .rl1_o      (rl1),
        .rl2_o      (rl2),
        .rl3_o      (rl3),
        .mode_o     (mode_code),
        .mode_load_o(mode_load),
        .rd_data    (rd_data),
        .irq        (irq)
    );

    wtc_counters #(
        .GUARD_ETUS(GUARD_ETUS)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .mode_load_i(mode_load),
        .cfg_i      (cfg),
        .rl1_i      (rl1),
        .rl2_i      (rl2),
        .rl3_i      (rl3),
        .start_i    (start),
        .start_rx_i (start_rx),
        .tick_i     (etu_tick),
        .term8_o    (term8),
        .termw_o    (termw)
    );

endmodule

// File: tb/sc_wait_timer_bench.sv
module sc_wait_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       card_active = 1'b1;
    logic       tx_active = 1'b0;
    logic       io_in = 1'b1;
    logic       etu_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sc_wait_timer u_sc_wait_timer (
        .clk(clk), .rst(rst), .card_active(card_active), .tx_active(tx_active),
        .io_in(io_in), .etu_tick(etu_tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // {req[3:0], mode, reload3, reload2, reload1, ticks[15:0], expected status[1:0]}
    localparam int NV = 14;
    localparam logic [53:0] VEC [NV] = '{
        {4'd4,  8'h05, 8'h00, 8'h00, 8'h05, 16'd4,   2'd0},  // R4 one short
        {4'd4,  8'h05, 8'h00, 8'h00, 8'h05, 16'd5,   2'd1},  // R4 terminal
        {4'd5,  8'h71, 8'h00, 8'h06, 8'h00, 16'd5,   2'd0},  // R5 one short
        {4'd5,  8'h71, 8'h00, 8'h06, 8'h00, 16'd6,   2'd2},  // R5 terminal
        {4'd6,  8'h7C, 8'h00, 8'h01, 8'h00, 16'd255, 2'd0},  // R6 one short
        {4'd6,  8'h7C, 8'h00, 8'h01, 8'h00, 16'd256, 2'd2},  // R6 terminal
        {4'd4,  8'h75, 8'h00, 8'h07, 8'h03, 16'd3,   2'd1},  // R4 in dual mode
        {4'd5,  8'h75, 8'h00, 8'h07, 8'h03, 16'd7,   2'd3},  // R5 in dual mode
        {4'd8,  8'h75, 8'h00, 8'h00, 8'h00, 16'd300, 2'd0},  // R8 all zero
        {4'd11, 8'h42, 8'h00, 8'h00, 8'h02, 16'd10,  2'd0},  // R11 unknown code
        {4'd9,  8'hF5, 8'h00, 8'h14, 8'h14, 16'd30,  2'd0},  // R9 both halted
        {4'd9,  8'hE5, 8'h00, 8'h00, 8'h0D, 16'd13,  2'd0},  // R9 8-bit halted
        {4'd9,  8'hF1, 8'h00, 8'h0C, 8'h00, 16'd12,  2'd2},  // R9 terminal on 12th
        {4'd10, 8'h85, 8'h00, 8'h00, 8'h14, 16'd25,  2'd0}   // R10 received START
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); etu_tick = 1'b1;
            @(negedge clk); etu_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic start_bit();
        @(negedge clk); io_in = 1'b0;
        repeat (4) @(negedge clk);
        io_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic restart(input logic [7:0] mode, input logic [7:0] r3,
                           input logic [7:0] r2, input logic [7:0] r1);
        logic [7:0] d;
        wr(3'd3, 8'h00);
        ticks(10);
        rd(3'd4, d);
        wr(3'd0, r1); wr(3'd1, r2); wr(3'd2, r3);
        wr(3'd3, mode);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd3, d); check(d, 8'h00, "R1 mode");
        rd(3'd4, d); check(d, 8'h00, "R1 status");
        rd(3'd0, d); check(d, 8'h00, "R1 reload1");
        check({7'd0, irq}, 8'h00, "R1 irq");

        // R2 mode write ignored while card inactive
        wr(3'd0, 8'h02);
        card_active = 1'b0;
        wr(3'd3, 8'h05);
        rd(3'd3, d); check(d, 8'h00, "R2 mode readback");
        start_bit(); ticks(12);
        rd(3'd4, d); check(d, 8'h00, "R2 no counting");
        card_active = 1'b1;

        // table of mode vectors
        for (int k = 0; k < NV; k++) begin
            restart(VEC[k][49:42], VEC[k][41:34], VEC[k][33:26], VEC[k][25:18]);
            start_bit();
            ticks(int'(VEC[k][17:2]));
            rd(3'd4, d);
            check(d, {6'd0, VEC[k][1:0]}, $sformatf("R%0d vector %0d", VEC[k][53:50], k));
        end

        // R3 edge inside a character is ignored
        restart(8'h71, 8'h00, 8'h0F, 8'h00);
        start_bit(); ticks(3);
        start_bit(); ticks(11);
        rd(3'd4, d); check(d, 8'h00, "R3 ignored edge, 14 ticks");
        ticks(1);
        rd(3'd4, d); check(d, 8'h02, "R3 ignored edge, 15 ticks");

        // R5 restart on later START
        restart(8'h71, 8'h00, 8'h0F, 8'h00);
        start_bit(); ticks(11);
        start_bit(); ticks(14);
        rd(3'd4, d); check(d, 8'h00, "R5 restarted count");
        ticks(1);
        rd(3'd4, d); check(d, 8'h02, "R5 restarted terminal");

        // R7 reload write mid-count
        restart(8'h71, 8'h00, 8'h0A, 8'h00);
        start_bit(); ticks(3);
        wr(3'd1, 8'h04);
        ticks(6);
        rd(3'd4, d); check(d, 8'h00, "R7 running count kept");
        ticks(1);
        rd(3'd4, d); check(d, 8'h02, "R7 old value used");
        start_bit(); ticks(3);
        rd(3'd4, d); check(d, 8'h00, "R7 new value pending");
        ticks(1);
        rd(3'd4, d); check(d, 8'h02, "R7 new value used");

        // R4 auto reload, not restarted by later START; R12 sticky and clear
        restart(8'h05, 8'h00, 8'h00, 8'h06);
        start_bit(); ticks(11);
        rd(3'd4, d); check(d, 8'h01, "R12 sticky after terminal");
        rd(3'd4, d); check(d, 8'h00, "R12 cleared by read");
        start_bit(); ticks(1);
        rd(3'd4, d); check(d, 8'h01, "R4 auto reload not restarted");

        // R10 transmitted START does not open the window
        restart(8'h85, 8'h00, 8'h00, 8'h14);
        tx_active = 1'b1;
        start_bit();
        tx_active = 1'b0;
        ticks(20);
        rd(3'd4, d); check(d, 8'h01, "R10 window not opened by tx START");

        // R13 interrupt masking
        restart(8'h05, 8'h00, 8'h00, 8'h02);
        wr(3'd5, 8'h01);
        start_bit(); ticks(2);
        check({7'd0, irq}, 8'h01, "R13 enabled bit");
        wr(3'd5, 8'h02);
        check({7'd0, irq}, 8'h00, "R13 masked bit");
        wr(3'd5, 8'h03);
        check({7'd0, irq}, 8'h01, "R13 both enabled");
        wr(3'd3, 8'h00);
        rd(3'd4, d);
        check({7'd0, irq}, 8'h00, "R13 cleared status");

        // R11 stop code halts a running counter
        restart(8'h05, 8'h00, 8'h00, 8'h04);
        start_bit(); ticks(2);
        wr(3'd3, 8'h00);
        ticks(6);
        rd(3'd4, d); check(d, 8'h00, "R11 stop mid-count");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule